// File: doc/BRIEF.md
# I/O and Boot ROM Address Decoder

This block watches host bus cycles on a local bus and decides whether each cycle targets a 16-location register window in the 64k I/O space or a boot ROM window in memory space. The I/O window position is set by two groups of compare bits. One group is matched against address bits 15–13 and the other against bits 9–5. Address bits 12–10 and bit 4 must be zero for a hit. The ROM window is set by a five-bit tag and a two-bit size code. The size code turns the ROM off, or chooses a 16k, 32k or 64k window, and in doing so sets how many tag bits are compared.

The compare values sit in a base register. Setup logic writes the whole register in one go through a load port after it has read an external serial configuration memory. The load port only takes effect in local-bus mode. In the other bus mode the decoder ignores the stored value and decodes with the built-in default: I/O base 0x300 and ROM off.

A small select state machine registers the result. It has three states:
- `ST_IDLE`: no select is driven.
- `ST_IO`: the I/O select is driven, together with a 4-bit register offset.
- `ST_ROM`: the ROM select is driven.

The transitions are:
- `ST_IDLE` → `ST_IO` on a sampled I/O hit.
- `ST_IDLE` → `ST_ROM` on a sampled ROM hit. An I/O hit wins if both are present.
- `ST_IO` → `ST_IDLE` when both I/O strobes are sampled inactive.
- `ST_ROM` → `ST_IDLE` when the memory read strobe is sampled inactive.

Top module: `iorom_decode`

## Requirements
- R1: After reset, `io_cs` and `rom_cs` are low, and the base register holds the default: I/O base 0x300 (bits 15–13 = 000, bits 9–5 = 11000), ROM size code 00, ROM tag 10011.
- R2: A sampled I/O hit raises `io_cs` one clock later. An I/O hit needs all of the following:
  - `ior_n` or `iow_n` low;
  - `addr[15:13]` equal to the high compare bits;
  - `addr[9:5]` equal to the low compare bits;
  - zero lines clear.
  Address bits 23–16 are ignored.
- R3: If any of `addr[4]`, `addr[10]`, `addr[11]` or `addr[12]` is 1, there is no I/O hit.
- R4: When `io_cs` rises, `io_ofs` equals `addr[3:0]` as sampled on the hit. It holds that value while `io_cs` stays high.
- R5: A select stays high while its strobe stays active. It drops on the clock after the strobe is sampled inactive.
- R6: ROM size code 00 never produces `rom_cs`.
- R7: Size code 01 compares `addr[18:14]` with all five tag bits. Code 10 compares `addr[18:15]` with tag bits 4–1. Code 11 compares `addr[18:16]` with tag bits 4–2.
- R8: A ROM hit needs `addr[19]` = 1. Address bits 23–20 are ignored.
- R9: Only `memrd_n` low can produce `rom_cs`; I/O strobes never can. `io_cs` and `rom_cs` are never high together.
- R10: The load port works as follows:
  - A `cfg_load` pulse in local-bus mode (`local_mode` = 1) writes all of `cfg_data` at once.
  - The field layout is I/O high compare [14:12], I/O low compare [11:7], size code [6:5], ROM tag [4:0].
  - Cycles sampled from the next clock on decode with the new value.
  - With `local_mode` = 0, loads are ignored and decoding uses the R1 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_mode | input | 1 | 1 = local-bus mode (stored register used), 0 = default decode |
| cfg_load | input | 1 | Load strobe for the base register |
| cfg_data | input | 15 | Full base register value to load |
| addr | input | 24 | Bus address |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memrd_n | input | 1 | Memory read strobe, active low |
| io_cs | output | 1 | Registered I/O window select |
| io_ofs | output | 4 | Register offset within the I/O window |
| rom_cs | output | 1 | Registered boot ROM select |

## Verification
The bench targets the points where a sloppy decoder leaks:
- The bench sets each of the four mandatory-zero lines in turn. A decoder that skipped one of them would alias the window and select on it.
- For each ROM size code, the bench probes an address that differs only in a masked-off bit and one that differs in a compared bit. A wrong mask would either reject a legal 32k/64k address or accept a foreign one.
- The bench drives bit 19 low, an I/O strobe at a ROM address, and size code 00. A decoder that ignored any of these would raise `rom_cs`.
- The bench reloads the register, then reloads it while `local_mode` is low. A decoder that used the stale base, or accepted the ignored load, would select the wrong window.

// File: rtl/iorom_pkg.sv
package iorom_pkg;

    localparam int ADDR_W  = 24;
    localparam int OFS_W   = 4;
    localparam int IOHI_W  = 3;
    localparam int IOLO_W  = 5;
    localparam int SIZE_W  = 2;
    localparam int TAG_W   = 5;
    localparam int CFG_W   = IOHI_W + IOLO_W + SIZE_W + TAG_W;

    // I/O decode bit positions (behaviour-defining)
    localparam int IOHI_LSB = 13;
    localparam int IOLO_LSB = 5;
    localparam int IO_SPAN  = 16;
    // Lines that must read zero for an I/O hit: 12, 11, 10 and 4
    localparam logic [IO_SPAN-1:0] IO_ZERO_MASK = 16'h1C10;

    // ROM decode bit positions
    localparam int ROM_TAG_LSB = 14;
    localparam int ROM_ONE_BIT = ROM_TAG_LSB + TAG_W;

    typedef struct packed {
        logic [IOHI_W-1:0] io_hi;
        logic [IOLO_W-1:0] io_lo;
        logic [SIZE_W-1:0] rom_size;
        logic [TAG_W-1:0]  rom_tag;
    } base_t;

    localparam base_t BASE_DEFAULT = '{
        io_hi:    3'b000,
        io_lo:    5'b11000,
        rom_size: 2'b00,
        rom_tag:  5'b10011
    };

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IO   = 2'd1,
        ST_ROM  = 2'd2
    } sel_state_e;

endpackage

// File: rtl/iorom_basereg.sv
module iorom_basereg
    import iorom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             local_mode,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_data,
    output base_t            eff_base
);

    base_t stored_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= BASE_DEFAULT;
        end else if (cfg_load && local_mode) begin
            stored_q <= base_t'(cfg_data);
        end
    end

    // Outside local-bus mode the decoder falls back to the fixed default
    always_comb begin
        eff_base = local_mode ? stored_q : BASE_DEFAULT;
    end

endmodule

// File: rtl/iorom_io_match.sv
module iorom_io_match
    import iorom_pkg::*;
(
    input  logic [IO_SPAN-1:0] io_addr,
    input  base_t              base,
    output logic               hit
);

    logic zero_ok;
    logic hi_ok;
    logic lo_ok;

    always_comb begin
        zero_ok = (io_addr & IO_ZERO_MASK) == '0;
        hi_ok   = io_addr[IOHI_LSB +: IOHI_W] == base.io_hi;
        lo_ok   = io_addr[IOLO_LSB +: IOLO_W] == base.io_lo;
        hit     = zero_ok && hi_ok && lo_ok;
    end

endmodule

// File: rtl/iorom_rom_match.sv
module iorom_rom_match
    import iorom_pkg::*;
(
    input  logic [TAG_W:0] rom_addr,   // address bits 19..14
    input  base_t          base,
    output logic           hit
);

    logic             enabled;
    logic [TAG_W-1:0] care;
    logic [TAG_W-1:0] bit_ok;

    assign enabled = base.rom_size != '0;

    // Size code k (1..3) ignores the lowest k-1 tag bits
    for (genvar i = 0; i < TAG_W; i++) begin : g_tag
        assign care[i]   = enabled && ({1'b0, base.rom_size} <= 3'(i + 1));
        assign bit_ok[i] = !care[i] || (rom_addr[i] == base.rom_tag[i]);
    end

    always_comb begin
        hit = enabled && rom_addr[TAG_W] && (&bit_ok);
    end

endmodule

// File: rtl/iorom_sel_fsm.sv
module iorom_sel_fsm
    import iorom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_strobe,
    input  logic             rom_req,
    input  logic             rom_strobe,
    input  logic [OFS_W-1:0] ofs_in,
    output logic             io_cs,
    output logic [OFS_W-1:0] io_ofs,
    output logic             rom_cs
);

    sel_state_e state_q;
    sel_state_e state_d;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (state_q == ST_IDLE && io_req) begin
            ofs_q <= ofs_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (io_req) begin
                    state_d = ST_IO;
                end else if (rom_req) begin
                    state_d = ST_ROM;
                end
            end
            ST_IO: begin
                if (!io_strobe) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ROM: begin
                if (!rom_strobe) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        io_cs  = 1'b0;
        rom_cs = 1'b0;
        io_ofs = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_IO: begin
                io_cs  = 1'b1;
                io_ofs = ofs_q;
            end
            ST_ROM: rom_cs = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/iorom_decode.sv
module iorom_decode
    import iorom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              local_mode,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              memrd_n,
    output logic              io_cs,
    output logic [OFS_W-1:0]  io_ofs,
    output logic              rom_cs
);

    base_t eff_base;
    logic  io_hit;
    logic  rom_hit;
    logic  io_strobe;
    logic  rom_strobe;
    logic  unused_hi;

    assign unused_hi  = ^addr[ADDR_W-1:ROM_ONE_BIT+1];
    assign io_strobe  = !ior_n || !iow_n;
    assign rom_strobe = !memrd_n;

    iorom_basereg u_basereg (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_mode (local_mode),
        .cfg_load   (cfg_load),
        .cfg_data   (cfg_data),
        .eff_base   (eff_base)
    );

    iorom_io_match u_io_match (
        .io_addr (addr[IO_SPAN-1:0]),
        .base    (eff_base),
        .hit     (io_hit)
    );

    iorom_rom_match u_rom_match (
        .rom_addr (addr[ROM_ONE_BIT:ROM_TAG_LSB]),
        .base     (eff_base),
        .hit      (rom_hit)
    );

    iorom_sel_fsm u_sel_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_req     (io_strobe && io_hit),
        .io_strobe  (io_strobe),
        .rom_req    (rom_strobe && rom_hit),
        .rom_strobe (rom_strobe),
        .ofs_in     (addr[OFS_W-1:0]),
        .io_cs      (io_cs),
        .io_ofs     (io_ofs),
        .rom_cs     (rom_cs)
    );

endmodule

// File: rtl/iorom_decode_chk.sv
module iorom_decode_chk
    import iorom_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ior_n,
    input logic              iow_n,
    input logic              memrd_n,
    input logic              io_cs,
    input logic [OFS_W-1:0]  io_ofs,
    input logic              rom_cs
);

    p_io_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_cs) |-> $past(!ior_n || !iow_n));

    p_io_zero_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_cs) |-> $past(addr[4] == 1'b0 && addr[12:10] == 3'b000));

    p_ofs_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_cs) |-> io_ofs == $past(addr[3:0]));

    p_io_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && ior_n && iow_n) |=> !io_cs);

    p_rom_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs && memrd_n) |=> !rom_cs);

    p_rom_a19_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_cs) |-> $past(addr[19]));

    p_rom_memrd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_cs) |-> $past(!memrd_n));

    p_sel_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cs && rom_cs));

endmodule

bind iorom_decode iorom_decode_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .ior_n   (ior_n),
    .iow_n   (iow_n),
    .memrd_n (memrd_n),
    .io_cs   (io_cs),
    .io_ofs  (io_ofs),
    .rom_cs  (rom_cs)
);

// File: tb/test_iorom_decode.sv
`timescale 1ns/1ps
module test_iorom_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        local_mode = 1'b1;
    logic        cfg_load = 1'b0;
    logic [14:0] cfg_data = '0;
    logic [23:0] addr = '0;
    logic        ior_n = 1'b1;
    logic        iow_n = 1'b1;
    logic        memrd_n = 1'b1;
    logic        io_cs;
    logic [3:0]  io_ofs;
    logic        rom_cs;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic       e_io;
        logic [3:0] e_ofs;
        logic       e_rom;
        int         due;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    iorom_decode i_iorom_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_mode (local_mode),
        .cfg_load   (cfg_load),
        .cfg_data   (cfg_data),
        .addr       (addr),
        .ior_n      (ior_n),
        .iow_n      (iow_n),
        .memrd_n    (memrd_n),
        .io_cs      (io_cs),
        .io_ofs     (io_ofs),
        .rom_cs     (rom_cs)
    );

    // Monitor: pops expected items when due and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (io_cs !== it.e_io || rom_cs !== it.e_rom ||
                (it.e_io && io_ofs !== it.e_ofs)) begin
                errors++;
                $display("FAIL %s: io_cs=%b ofs=%h rom_cs=%b, expected io_cs=%b ofs=%h rom_cs=%b",
                         it.tag, io_cs, io_ofs, rom_cs, it.e_io, it.e_ofs, it.e_rom);
            end
        end
    end

    task automatic push(input logic eio, input logic [3:0] eofs, input logic erom, input string tag);
        exp_t it;
        it.e_io = eio; it.e_ofs = eofs; it.e_rom = erom; it.due = cyc + 1; it.tag = tag;
        q.push_back(it);
    endtask

    // kind: 0 = I/O read, 1 = I/O write, 2 = memory read
    task automatic access(input logic [23:0] a, input int kind, input int hold,
                          input logic eio, input logic erom, input string tag);
        @(negedge clk);
        addr = a;
        ior_n   = (kind != 0);
        iow_n   = (kind != 1);
        memrd_n = (kind != 2);
        for (int k = 0; k < hold; k++) begin
            if (k > 0) @(negedge clk);
            push(eio, a[3:0], erom, tag);
        end
        @(negedge clk);
        ior_n = 1'b1; iow_n = 1'b1; memrd_n = 1'b1;
        push(1'b0, 4'h0, 1'b0, {tag, " release R5"});
        @(negedge clk);
    endtask

    task automatic load(input logic [14:0] d);
        @(negedge clk);
        cfg_load = 1'b1; cfg_data = d;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (io_cs !== 1'b0 || rom_cs !== 1'b0) begin
            errors++;
            $display("FAIL R1 during reset: io_cs=%b rom_cs=%b expected 0 0", io_cs, rom_cs);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (io_cs !== 1'b0 || rom_cs !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: io_cs=%b rom_cs=%b expected 0 0", io_cs, rom_cs);
        end

        // R1/R2/R4: default base 0x300, offsets captured
        access(24'h000305, 0, 1, 1'b1, 1'b0, "R1 default base read");
        access(24'hAB030F, 1, 1, 1'b1, 1'b0, "R2 write, upper bits ignored");
        access(24'h00030A, 0, 1, 1'b1, 1'b0, "R4 offset A");
        // R3: mandatory-zero lines
        access(24'h000310, 0, 1, 1'b0, 1'b0, "R3 A4 set");
        access(24'h000700, 0, 1, 1'b0, 1'b0, "R3 A10 set");
        access(24'h000B00, 1, 1, 1'b0, 1'b0, "R3 A11 set");
        access(24'h001300, 0, 1, 1'b0, 1'b0, "R3 A12 set");
        access(24'h000200, 0, 1, 1'b0, 1'b0, "R2 A8 mismatch");
        // R5: held strobe keeps select
        access(24'h000303, 0, 3, 1'b1, 1'b0, "R5 held I/O read");
        // R6: size 00 default, ROM disabled
        access(24'h0CC000, 2, 1, 1'b0, 1'b0, "R6 size 00 disabled");

        // R7/R10: size 01, tag 10011 -> 0x0C33
        load(15'h0C33);
        access(24'h0CC000, 2, 2, 1'b0, 1'b1, "R7 size01 match R10 new value");
        access(24'h0C8000, 2, 1, 1'b0, 1'b0, "R7 size01 RA14 compared");
        access(24'h04C000, 2, 1, 1'b0, 1'b0, "R8 A19 low");
        access(24'hFCC000, 2, 1, 1'b0, 1'b1, "R8 bits 23-20 ignored");
        access(24'h0CC000, 0, 1, 1'b0, 1'b0, "R9 ior at ROM address");
        access(24'h0CC000, 1, 1, 1'b0, 1'b0, "R9 iow at ROM address");
        access(24'h000301, 0, 1, 1'b1, 1'b0, "R10 I/O base kept after load");

        // size 10 -> 0x0C53
        load(15'h0C53);
        access(24'h0C8000, 2, 1, 1'b0, 1'b1, "R7 size10 RA14 masked");
        access(24'h0C0000, 2, 1, 1'b0, 1'b0, "R7 size10 RA15 compared");
        // size 11 -> 0x0C73
        load(15'h0C73);
        access(24'h0C0000, 2, 1, 1'b0, 1'b1, "R7 size11 RA15 masked");
        access(24'h0D0000, 2, 1, 1'b0, 1'b0, "R7 size11 RA16 compared");

        // R10: new I/O base 0xA020 (hi 101, lo 00001), size 01 -> 0x50B3
        load(15'h50B3);
        access(24'h00A027, 0, 1, 1'b1, 1'b0, "R10 new I/O base");
        access(24'h000300, 0, 1, 1'b0, 1'b0, "R10 old I/O base gone");

        // R10: other bus mode uses default and ignores loads
        @(negedge clk);
        local_mode = 1'b0;
        access(24'h000302, 0, 1, 1'b1, 1'b0, "R10 default in other mode");
        access(24'h00A020, 0, 1, 1'b0, 1'b0, "R10 stored base unused in other mode");
        access(24'h0CC000, 2, 1, 1'b0, 1'b0, "R10 ROM off in other mode");
        load(15'h0C33);
        @(negedge clk);
        local_mode = 1'b1;
        access(24'h00A024, 0, 1, 1'b1, 1'b0, "R10 load ignored in other mode");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule